// File: doc/BRIEF.md
# Word-Framed Serial Register Target

This block is the serial target of a four-channel pulse-width controller. A host drives 16-bit frames over a SPI link, and the chip select goes high after every word. The upper byte of each frame holds an address together with a write flag. The lower byte holds the data. A write frame stores its data byte in an 8-bit register. A read frame names a register, and its contents come back on MISO during the next frame. A burst of N reads therefore needs N+1 frames, and the host throws away the first word it receives.

The register file holds these values and drives them straight to the channel logic:

- the global mode field;
- the per-channel polarity-invert bits;
- the per-channel enable bits;
- four frequency words;
- four duty words;
- a watchdog byte.

SCLK, chip select and MOSI are brought into the system clock domain through two-stage synchronisers, and all decoding runs on the system clock. The link is a plain serial port with no valid/ready signals, because the host cannot be stalled. The outputs to the channels are plain levels.

Top module: `pwm_spi_regs`

## Requirements
- R1: The link uses SPI mode 0, MSB first. MOSI is taken on each SCLK rising edge while cs_n is low. MISO changes after SCLK falling edges, shows bit 15 of the reply before the first rising edge, and is 0 while cs_n is high.
- R2: In a frame, bits 15:8 are the address field and bits 7:0 are the data field. When bit 15 is 1, the frame is a write, and the data byte is stored in the register at address bits 14:8.
- R3: The word shifted out during a frame is the reply to the previous complete frame. After a read, bits 15:14 of the reply are 0 and bits 13:0 are the register value, zero-extended. After a write, the reply is 0. The first frame after reset also returns 0.
- R4: A read whose data bit 7 is 0 returns 0. Data bit 7 must be 1 to read a control register.
- R5: Any address not listed in R6 reads as 0. Writes to such an address change no output.
- R6: The mapped addresses are 0x00 (global control), 0x05 (polarity), 0x07 (enable), 0x08–0x0B (frequency of channels 1–4), 0x0C–0x0F (duty of channels 1–4) and 0x14 (watchdog). Every register stores and reads back all 8 bits.
- R7: mode equals bits 7:6 of the global control register. A value of 1 means normal operation.
- R8: pol_inv for channel c (1..4), at bit c-1, equals bit c+1 of the polarity register. ch_en for channel c equals bit 3+c of the enable register.
- R9: freq_cfg and duty_cfg carry the frequency and duty register of channel c in bits [8c-1:8c-8]. wdog_cfg carries the watchdog register.
- R10: A frame counts only if exactly 16 SCLK rising edges occur between the fall and the rise of cs_n. Any other frame changes no register and leaves the pending reply as it was.
- R11: After reset, all registers are 0. The device is then in a non-normal mode with every channel disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| mode | output | 2 | Global mode field |
| pol_inv | output | 4 | Per-channel polarity invert |
| ch_en | output | 4 | Per-channel enable |
| freq_cfg | output | 32 | Frequency words, channel 1 in the low byte |
| duty_cfg | output | 32 | Duty words, channel 1 in the low byte |
| wdog_cfg | output | 8 | Watchdog configuration byte |

## Verification
The assertions assume that every SCLK level and every MOSI value is held for at least three system clocks, so that each serial edge is seen exactly once after synchronisation. They also assume that MOSI is stable across each sampled rising edge. The stimulus keeps both SCLK half periods and the chip-select setup and hold at eight system clocks. It changes MOSI only while SCLK is low. Random frames are mixed with deliberately short and long frames to exercise the rejection rule.

// File: rtl/pwm_spi_pkg.sv
package pwm_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 5;

  localparam logic [6:0] A_GLOBAL = 7'h00;
  localparam logic [6:0] A_POL    = 7'h05;
  localparam logic [6:0] A_ENA    = 7'h07;
  localparam logic [6:0] A_FREQ0  = 7'h08;
  localparam logic [6:0] A_DUTY0  = 7'h0C;
  localparam logic [6:0] A_WDOG   = 7'h14;

  typedef struct packed {
    logic       wr;
    logic [6:0] addr;
    logic [7:0] data;
  } frame_t;
endpackage

// File: rtl/pwm_spi_sync.sv
module pwm_spi_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);
  logic [2:0] sck_q, csn_q;
  logic [1:0] mo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 3'b000;
      csn_q <= 3'b111;
      mo_q  <= 2'b00;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      csn_q <= {csn_q[1:0], cs_n};
      mo_q  <= {mo_q[0], mosi};
    end
  end

  assign sclk_rise = sck_q[1] & ~sck_q[2];
  assign sclk_fall = ~sck_q[1] & sck_q[2];
  assign cs_act    = ~csn_q[1];
  assign cs_start  = ~csn_q[1] & csn_q[2];
  assign cs_end    = csn_q[1] & ~csn_q[2];
  assign mosi_s    = mo_q[1];
endmodule

// File: rtl/pwm_spi_shifter.sv
module pwm_spi_shifter
  import pwm_spi_pkg::*;
#(
  parameter int W = FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         cs_act,
  input  logic         cs_start,
  input  logic         cs_end,
  input  logic         mosi_s,
  input  logic [W-1:0] resp,
  output logic         miso,
  output logic         frm_vld,
  output logic [W-1:0] frm_word
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

  logic [CNT_W-1:0] bitcnt;
  logic [W-1:0]     rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
    end else if (cs_start) begin
      bitcnt <= '0;
      tx_sh  <= resp;
    end else if (cs_act) begin
      if (sclk_rise) begin
        rx_sh <= {rx_sh[W-2:0], mosi_s};
        if (bitcnt != OVER) bitcnt <= bitcnt + 1'b1;
      end
      if (sclk_fall && bitcnt != '0) tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end

  assign miso     = cs_act & tx_sh[W-1];
  assign frm_vld  = cs_end && (bitcnt == FULL);
  assign frm_word = rx_sh;

  p_frame_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |-> !cs_act);
  p_count_cleared_on_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> bitcnt == '0);
  p_count_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= OVER);
endmodule

// File: rtl/pwm_spi_regfile.sv
module pwm_spi_regfile
  import pwm_spi_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_vld,
  input  frame_t             frm,
  output logic [FRAME_W-1:0] resp,
  output logic [1:0]         mode,
  output logic [NCH-1:0]     pol_inv,
  output logic [NCH-1:0]     ch_en,
  output logic [NCH*8-1:0]   freq_cfg,
  output logic [NCH*8-1:0]   duty_cfg,
  output logic [7:0]         wdog_cfg
);
  localparam int RESP_PAD = FRAME_W - 2 - BYTE_W;

  logic [7:0] glob_r, pol_r, ena_r, wdog_r;
  logic [7:0] freq_r [NCH];
  logic [7:0] duty_r [NCH];
  logic [7:0] rd_byte;
  logic       hit;

  always_comb begin
    rd_byte = '0;
    hit     = 1'b1;
    unique case (frm.addr)
      A_GLOBAL: rd_byte = glob_r;
      A_POL:    rd_byte = pol_r;
      A_ENA:    rd_byte = ena_r;
      A_WDOG:   rd_byte = wdog_r;
      default: begin
        hit = 1'b0;
        for (int c = 0; c < NCH; c++) begin
          if (frm.addr == A_FREQ0 + 7'(c)) begin rd_byte = freq_r[c]; hit = 1'b1; end
          if (frm.addr == A_DUTY0 + 7'(c)) begin rd_byte = duty_r[c]; hit = 1'b1; end
        end
      end
    endcase
  end

  wire wr_go = frm_vld && frm.wr && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_r <= '0; pol_r <= '0; ena_r <= '0; wdog_r <= '0; resp <= '0;
    end else if (frm_vld) begin
      if (frm.wr || !frm.data[7]) resp <= '0;
      else resp <= {2'b00, {RESP_PAD{1'b0}}, rd_byte};
      if (wr_go && frm.addr == A_GLOBAL) glob_r <= frm.data;
      if (wr_go && frm.addr == A_POL)    pol_r  <= frm.data;
      if (wr_go && frm.addr == A_ENA)    ena_r  <= frm.data;
      if (wr_go && frm.addr == A_WDOG)   wdog_r <= frm.data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_r[c] <= '0;
        duty_r[c] <= '0;
      end else begin
        if (wr_go && frm.addr == A_FREQ0 + 7'(c)) freq_r[c] <= frm.data;
        if (wr_go && frm.addr == A_DUTY0 + 7'(c)) duty_r[c] <= frm.data;
      end
    end
    assign freq_cfg[c*8 +: 8] = freq_r[c];
    assign duty_cfg[c*8 +: 8] = duty_r[c];
    assign pol_inv[c] = pol_r[c + 2];
    assign ch_en[c]   = ena_r[c + 4];
  end

  assign mode     = glob_r[7:6];
  assign wdog_cfg = wdog_r;

  p_write_reply_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && frm.wr |=> resp == '0);
  p_unflagged_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && !frm.wr && !frm.data[7] |=> resp == '0);
  p_unmapped_write_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && frm.wr && !hit |=> $stable({glob_r, pol_r, ena_r, wdog_r, freq_cfg, duty_cfg}));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable({glob_r, pol_r, ena_r, wdog_r, freq_cfg, duty_cfg, resp}));
  p_reply_top_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp[FRAME_W-1:FRAME_W-2] == 2'b00);
endmodule

// File: rtl/pwm_spi_regs.sv
module pwm_spi_regs
  import pwm_spi_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic [1:0]       mode,
  output logic [NCH-1:0]   pol_inv,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH*8-1:0] freq_cfg,
  output logic [NCH*8-1:0] duty_cfg,
  output logic [7:0]       wdog_cfg
);
  logic sclk_rise, sclk_fall, cs_act, cs_start, cs_end, mosi_s, frm_vld;
  logic [FRAME_W-1:0] frm_word, resp;

  pwm_spi_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
  );

  pwm_spi_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s),
    .resp(resp), .miso(miso), .frm_vld(frm_vld), .frm_word(frm_word)
  );

  pwm_spi_regfile #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm(frame_t'(frm_word)),
    .resp(resp), .mode(mode), .pol_inv(pol_inv), .ch_en(ch_en),
    .freq_cfg(freq_cfg), .duty_cfg(duty_cfg), .wdog_cfg(wdog_cfg)
  );

  p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !miso);
endmodule

// File: tb/tb_pwm_spi_regs.sv
module tb_pwm_spi_regs;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso;
  logic [1:0] mode;
  logic [3:0] pol_inv, ch_en;
  logic [31:0] freq_cfg, duty_cfg;
  logic [7:0] wdog_cfg;
  int n_run = 0, n_fail = 0;
  logic [7:0] model [0:127];
  logic [15:0] exp_resp;

  always #2.5 clk = ~clk;

  pwm_spi_regs dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .mode(mode), .pol_inv(pol_inv), .ch_en(ch_en),
    .freq_cfg(freq_cfg), .duty_cfg(duty_cfg), .wdog_cfg(wdog_cfg));

  function automatic bit mapped(input logic [6:0] a);
    return a == 7'h00 || a == 7'h05 || a == 7'h07 || (a >= 7'h08 && a <= 7'h0F) || a == 7'h14;
  endfunction

  function automatic logic [15:0] reply_of(input logic [15:0] w);
    if (w[15] || !w[7] || !mapped(w[14:8])) return 16'h0000;
    return {8'h00, model[w[14:8]]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shifts nbits of w (MSB first); returns bits seen on miso
  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 0;
    waitc(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15 - (i % 16)];
      waitc(8);
      r = {r[14:0], miso};
      sclk = 1;
      waitc(8);
      sclk = 0;
    end
    waitc(8);
    cs_n = 1;
    waitc(8);
  endtask

  task automatic frame(input logic [15:0] w, input string req);
    logic [15:0] r;
    xfer(w, 16, r);
    chk(req, r, exp_resp);
    if (w[15] && mapped(w[14:8])) model[w[14:8]] = w[7:0];
    exp_resp = reply_of(w);
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " mode R7"}, mode, model[7'h00][7:6]);
    chk({req, " pol R8"}, pol_inv, model[7'h05][5:2]);
    chk({req, " en R8"}, ch_en, model[7'h07][7:4]);
    chk({req, " freq R9"}, freq_cfg, {model[7'h0B], model[7'h0A], model[7'h09], model[7'h08]});
    chk({req, " duty R9"}, duty_cfg, {model[7'h0F], model[7'h0E], model[7'h0D], model[7'h0C]});
    chk({req, " wdog R9"}, wdog_cfg, model[7'h14]);
  endtask

  initial begin
    int unused_seed;
    logic [15:0] r;
    logic [6:0] a;
    logic [6:0] mapped_list [13];
    unused_seed = $urandom(32'd20240611);
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    mapped_list = '{7'h00, 7'h05, 7'h07, 7'h08, 7'h09, 7'h0A, 7'h0B,
                    7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h14, 7'h00};
    exp_resp = 16'h0000;
    waitc(4); rst_n = 1; waitc(4);

    chk_outputs("R11 reset");
    chk("R1 miso idle", miso, 1'b0);

    frame(16'h8040, "R3 first reply zero");
    chk("R7 normal mode", mode, 2'd1);
    frame(16'h8504, "R2 write pol");
    chk("R8 pol ch1 only", pol_inv, 4'b0001);
    frame(16'h8710, "R2 write en");
    chk("R8 en ch1 only", ch_en, 4'b0001);
    frame(16'h0580, "R3 reply after write");
    frame(16'h0780, "R3 read pol returned");
    frame(16'h0700, "R3 read en returned");
    frame(16'h0080, "R4 unflagged read zero");
    frame(16'h0000, "R3 read global returned");
    frame(16'hA0FF, "R5 unmapped write");
    chk_outputs("R5 unmapped write inert");
    frame(16'h2080, "R5 reply");
    frame(16'h1480, "R5 unmapped read zero");
    frame(16'h0000, "R6 wdog read");

    // partial and oversize frames
    frame(16'h8F5A, "R9 duty4 write");
    frame(16'h0F80, "R3 reply");
    xfer(16'h8FA5, 10, r);
    chk_outputs("R10 short frame ignored");
    xfer(16'h8FA5, 17, r);
    chk_outputs("R10 long frame ignored");
    frame(16'h0000, "R10 pending reply kept");

    for (int k = 0; k < 150; k++) begin
      logic [15:0] w;
      if ($urandom_range(3) == 0) a = 7'($urandom);
      else a = mapped_list[$urandom_range(12)];
      w = {1'($urandom), a, 8'($urandom)};
      frame(w, "R2 R3 random frame");
      if (k % 10 == 0) chk_outputs("R6 random");
    end
    chk_outputs("R6 final");

    rst_n = 0; waitc(3); rst_n = 1; waitc(3);
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    exp_resp = 16'h0000;
    chk_outputs("R11 second reset");
    frame(16'h0080, "R11 reply zero after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule